// File: doc/BRIEF.md
# Bulk-Erase, Byte-Program and Verify Sequencer

This block drives a byte-wide nonvolatile memory that can only be returned to all-ones by a whole-array erase and then written one byte at a time. After one `start` request it runs the whole flow with no further help. First it turns on both high-voltage switches (one for the output-enable pin, one for the A9 pin) and applies a long erase strobe. It then reads every location and expects 8'hFF. Next it turns on only the output-enable high voltage and gives each byte one short write strobe, with the address and data taken from an external data source. Last it reads every location back and compares it with the source.

Each high-voltage switch is turned on some time before a strobe, held for some time after it, and followed by a recovery wait before any read begins. The block reports pass or fail. On a failure it also reports the first failing address, the byte that was read, and which phase failed. Every duration is a cycle-count parameter. The last address is derived from the address width.

Top module: `erase_prog_seq`

## Requirements
- R1: After reset, and while idle, chip enable, output enable and write enable are high (inactive), both high-voltage enables are off, and `busy`, `done` and `pass` are 0.
- R2: Exactly one erase strobe (write enable low for ERASE_CYC cycles) is issued per run. During it chip enable is low and both high-voltage enables are on. The A9 enable is never on without the output-enable high voltage.
- R3: The blank check reads addresses 0 up to 2^ADDR_W-1 in order. The first byte that is not 8'hFF ends the run with `pass`=0, `fail_blank`=1, and that address and byte latched. No program strobe is issued after such a failure.
- R4: Each program strobe holds write enable low for PROG_CYC cycles. During it the output-enable high voltage is on, the A9 enable is off, chip enable is low, and the data bus is driven with `src_data` for the current address.
- R5: Address, data and chip enable stay unchanged for at least GAP_CYC cycles before every strobe's falling edge and after its rising edge. The output-enable high voltage is on for at least GAP_CYC cycles before any strobe falls.
- R6: After a high-voltage enable is removed, output enable goes low for a read only after at least GAP_CYC cycles.
- R7: The final verify compares each byte read with `src_data`. The first mismatch ends the run with `pass`=0 and `fail_blank`=0, and latches that address and the byte read.
- R8: A high-voltage enable is never on while output enable is low.
- R9: Program strobes go to each address exactly once, in increasing order from 0 to 2^ADDR_W-1, and all of them come before the final verify.
- R10: A run with no mismatch ends with `done`=1 and `pass`=1. A new `start` from idle or done clears the previous result and runs the flow again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (accepted when not busy) |
| src_data | input | 8 | Source byte for address `mem_addr` |
| mem_dq_in | input | 8 | Byte read from the memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 8 | Byte driven to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| hv_oe_en | output | 1 | High-voltage switch enable for the output-enable pin |
| hv_a9_en | output | 1 | High-voltage switch enable for the A9 pin |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Last run passed |
| fail_blank | output | 1 | Failure found during the blank check |
| fail_addr | output | ADDR_W | First failing address |
| fail_data | output | 8 | Byte read at the first failing address |

## Verification
The bench uses a small array and a bit-accurate memory model. It plants a stuck-at-zero bit at each address in turn, which should be caught by the blank check. A design that skipped the blank check or moved past the failure would program a bad part and report the wrong address. It also plants a stuck-at-one bit at each address in turn, which the final verify must catch only when the source byte needs that bit cleared. A verify that compared the wrong data, or that stopped after the first byte, would pass bad parts or fail good ones. Monitors measure every strobe width, the setup, hold and recovery spacing, and the order of program addresses. Any off-by-one in the cycle counters shows up as a timing error.

// File: rtl/erase_prog_seq.sv
module erase_prog_seq #(
  parameter int ADDR_W    = 17,
  parameter int ERASE_CYC = 5_000_000,
  parameter int PROG_CYC  = 750,
  parameter int GAP_CYC   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        src_data,
  input  logic [7:0]        mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              hv_oe_en,
  output logic              hv_a9_en,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail_blank,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_data
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam int TW = $clog2(ERASE_CYC + PROG_CYC + GAP_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ESU, S_EPW, S_EHD, S_ERC, S_BLK,
    S_PHV, S_PSU, S_PPW, S_PHD, S_PRC, S_VFY, S_DONE
  } st_t;

  st_t st;
  logic [TW-1:0] tmr, lim;
  logic [ADDR_W-1:0] addr;
  logic rd_ph;
  logic [7:0] expect_b;
  logic tick;

  assign mem_addr   = addr;
  assign mem_dq_out = src_data;
  assign busy       = (st != S_IDLE) && (st != S_DONE);
  assign done       = (st == S_DONE);
  assign mem_ce_n   = !busy;
  assign mem_oe_n   = !((st == S_BLK) || (st == S_VFY));
  assign mem_we_n   = !((st == S_EPW) || (st == S_PPW));
  assign mem_dq_oe  = (st == S_PSU) || (st == S_PPW) || (st == S_PHD);
  assign hv_a9_en   = (st == S_ESU) || (st == S_EPW) || (st == S_EHD);
  assign hv_oe_en   = hv_a9_en || (st == S_PHV) || mem_dq_oe;
  assign expect_b   = (st == S_BLK) ? 8'hFF : src_data;

  always_comb begin
    case (st)
      S_EPW:   lim = TW'(ERASE_CYC);
      S_PPW:   lim = TW'(PROG_CYC);
      default: lim = TW'(GAP_CYC);
    endcase
  end
  assign tick = (tmr == lim - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; addr <= '0; rd_ph <= 1'b0;
      pass <= 1'b0; fail_blank <= 1'b0; fail_addr <= '0; fail_data <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          st <= S_ESU; tmr <= '0; addr <= '0; rd_ph <= 1'b0;
          pass <= 1'b0; fail_blank <= 1'b0; fail_addr <= '0; fail_data <= '0;
        end
        S_BLK, S_VFY: begin
          rd_ph <= !rd_ph;
          if (rd_ph) begin
            if (mem_dq_in != expect_b) begin
              fail_blank <= (st == S_BLK);
              fail_addr  <= addr;
              fail_data  <= mem_dq_in;
              st         <= S_DONE;
            end else if (addr == LAST) begin
              addr <= '0;
              tmr  <= '0;
              if (st == S_BLK) st <= S_PHV;
              else begin st <= S_DONE; pass <= 1'b1; end
            end else addr <= addr + 1'b1;
          end
        end
        default: if (!tick) tmr <= tmr + TW'(1);
          else begin
            tmr <= '0;
            case (st)
              S_ESU: st <= S_EPW;
              S_EPW: st <= S_EHD;
              S_EHD: st <= S_ERC;
              S_ERC: st <= S_BLK;
              S_PHV: st <= S_PSU;
              S_PSU: st <= S_PPW;
              S_PPW: st <= S_PHD;
              S_PHD: if (addr == LAST) begin st <= S_PRC; addr <= '0; end
                     else begin st <= S_PSU; addr <= addr + 1'b1; end
              default: st <= S_VFY;
            endcase
          end
      endcase
    end
  end

  p_hv_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hv_oe_en && !mem_oe_n));
  p_a9_needs_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hv_a9_en |-> (hv_oe_en && !mem_ce_n));
  p_prog_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !hv_a9_en) |-> (mem_dq_oe && hv_oe_en && !mem_ce_n));
  p_stable_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_we_n && mem_oe_n && !hv_oe_en));
  p_pass_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && !fail_blank));
endmodule

// File: tb/erase_prog_seq_tb_top.sv
module erase_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int N = 1 << AW;
  localparam int ER = 20;
  localparam int PR = 6;
  localparam int GP = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] src_data, mem_dq_in, mem_dq_out, fail_data;
  logic [AW-1:0] mem_addr, fail_addr;
  logic mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n, hv_oe_en, hv_a9_en;
  logic busy, done, pass, fail_blank;

  erase_prog_seq #(.ADDR_W(AW), .ERASE_CYC(ER), .PROG_CYC(PR), .GAP_CYC(GP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .hv_oe_en(hv_oe_en), .hv_a9_en(hv_a9_en), .busy(busy), .done(done), .pass(pass),
    .fail_blank(fail_blank), .fail_addr(fail_addr), .fail_data(fail_data));

  always #(CLK_PERIOD/2) clk = !clk;

  logic [7:0] mem [N], src [N], s0 [N], s1 [N];
  assign src_data  = src[mem_addr];
  assign mem_dq_in = (!mem_oe_n && !mem_ce_n) ? mem[mem_addr] : 8'h00;

  int n_erase = 0, n_prog = 0, ord_err = 0, su_err = 0, hd_err = 0;
  int wd_err = 0, rc_err = 0, sf_err = 0;
  int since_chg = 1000, hv_on = 1000, hv_off = 1000, hi_cnt = 1000, low_cnt = 0, ord_next = 0;
  logic is_er = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [7:0] p_dq = '0;
  logic p_dqoe = 1'b0, p_ce = 1'b1, p_hv = 1'b0, p_we = 1'b1, p_oe = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] = 8'h3C;
    end else begin
      logic chg;
      chg = (mem_addr != p_addr) || (mem_dq_out != p_dq) || (mem_dq_oe != p_dqoe) ||
            (mem_ce_n != p_ce) || (hv_oe_en != p_hv);
      since_chg = chg ? 0 : (since_chg < 1000 ? since_chg + 1 : since_chg);
      hv_on  = (hv_oe_en && !p_hv) ? 0 : (hv_on < 1000 ? hv_on + 1 : hv_on);
      hv_off = (!hv_oe_en && p_hv) ? 0 : (hv_off < 1000 ? hv_off + 1 : hv_off);
      hi_cnt = (mem_we_n && !p_we) ? 0 : (hi_cnt < 1000 ? hi_cnt + 1 : hi_cnt);
      if (chg && mem_we_n && hi_cnt < GP) hd_err++;
      if (hv_oe_en && !mem_oe_n) sf_err++;
      if (hv_a9_en && !hv_oe_en) sf_err++;
      if (!mem_we_n && p_we) begin
        if (since_chg < GP || hv_on < GP || mem_ce_n) su_err++;
        low_cnt = 1;
        if (hv_a9_en) begin
          is_er = 1'b1; n_erase++; ord_next = 0;
          for (int i = 0; i < N; i++) mem[i] = ~s0[i];
        end else begin
          is_er = 1'b0; n_prog++;
          if (int'(mem_addr) != ord_next || !mem_dq_oe || !hv_oe_en) ord_err++;
          ord_next++;
          mem[mem_addr] = ((mem[mem_addr] & mem_dq_out) | s1[mem_addr]) & ~s0[mem_addr];
        end
      end else if (!mem_we_n) low_cnt++;
      if (mem_we_n && !p_we && low_cnt != (is_er ? ER : PR)) wd_err++;
      if (!mem_oe_n && p_oe && hv_off < GP) rc_err++;
      p_addr = mem_addr; p_dq = mem_dq_out; p_dqoe = mem_dq_oe; p_ce = mem_ce_n;
      p_hv = hv_oe_en; p_we = mem_we_n; p_oe = mem_oe_n;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int seed, input int s0a, input logic [7:0] s0m,
                     input int s1a, input logic [7:0] s1m);
    int b_er, b_pr, b_err, t, e_blank_a, e_ver_a;
    logic [7:0] e_data;
    logic [7:0] fin [N];
    for (int i = 0; i < N; i++) begin
      s0[i] = (i == s0a) ? s0m : 8'h00;
      s1[i] = (i == s1a) ? s1m : 8'h00;
      src[i] = 8'((i * 37 + seed * 11) ^ 8'h5A);
    end
    e_blank_a = -1; e_ver_a = -1; e_data = 8'h00;
    for (int i = N - 1; i >= 0; i--) if (s0[i] != 8'h00) begin e_blank_a = i; e_data = ~s0[i]; end
    for (int i = 0; i < N; i++) fin[i] = (src[i] | s1[i]) & ~s0[i];
    if (e_blank_a < 0)
      for (int i = N - 1; i >= 0; i--) if (fin[i] != src[i]) begin e_ver_a = i; e_data = fin[i]; end
    b_er = n_erase; b_pr = n_prog;
    b_err = ord_err + su_err + hd_err + wd_err + rc_err + sf_err;
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, "R10 run finished", done, 1);
    chk(n_erase - b_er == 1, "R2 one erase strobe", n_erase - b_er, 1);
    chk(n_prog - b_pr == (e_blank_a >= 0 ? 0 : N), "R3/R9 program strobe count", n_prog - b_pr,
        e_blank_a >= 0 ? 0 : N);
    chk(ord_err + su_err + hd_err + wd_err + rc_err + sf_err == b_err,
        "R4 R5 R6 R8 R9 strobe timing/order", ord_err + su_err + hd_err + wd_err + rc_err + sf_err, b_err);
    if (e_blank_a >= 0) begin
      chk(!pass && fail_blank, "R3 blank fail flags", {pass, fail_blank}, 1);
      chk(int'(fail_addr) == e_blank_a, "R3 blank fail addr", fail_addr, e_blank_a);
      chk(fail_data == e_data, "R3 blank fail data", fail_data, e_data);
    end else if (e_ver_a >= 0) begin
      chk(!pass && !fail_blank, "R7 verify fail flags", {pass, fail_blank}, 0);
      chk(int'(fail_addr) == e_ver_a, "R7 verify fail addr", fail_addr, e_ver_a);
      chk(fail_data == e_data, "R7 verify fail data", fail_data, e_data);
    end else begin
      chk(pass && !fail_blank, "R10 pass", pass, 1);
      for (int i = 0; i < N; i++) chk(mem[i] == src[i], "R4 programmed byte", mem[i], src[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!hv_oe_en && !hv_a9_en, "R1 hv off", {hv_oe_en, hv_a9_en}, 0);
    chk(!busy && !done && !pass, "R1 status", {busy, done, pass}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && mem_ce_n && !hv_oe_en, "R1 idle after reset", busy, 0);
    run(0, -1, 8'h00, -1, 8'h00);
    run(5, -1, 8'h00, -1, 8'h00);
    for (int a = 0; a < N; a++) run(a, a, 8'(1 << a), -1, 8'h00);
    for (int a = 0; a < N; a++) run(a + 2, -1, 8'h00, a, 8'h81);
    run(9, -1, 8'h00, -1, 8'h00);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule